// File: doc/BRIEF.md
# PWM Duty Value Bank with Broadcast Load

This block holds six 16-bit duty values for a multi-channel PWM generator. Values are written through one write port. A 2-bit load mode decides whether a write to register 0 stays in register 0 or is also copied into a group of the other registers. This lets one write set the duty of every channel, or of the low channel group, on a single clock edge. All six values are driven out in parallel to the compare logic. A combinational read port returns any one of them.

The write port is a valid/ready stream. A beat transfers on every rising edge where `wr_valid` is high, because `wr_ready` is tied high and the bank never applies back-pressure. The sender may hold `wr_valid` high on back-to-back cycles, and each such cycle is a separate write. The load mode is a separate control register. It is loaded from `cfg_mode` on a `cfg_we` pulse, and only while `enh_en` is 1.

Top module: `pwmv_bcast_loader`

## Requirements
- R1: On reset all six values are 0 and the load mode is 0 (independent access).
- R2: In mode 0, a write to address 0 changes only value 0.
- R3: In mode 1, a write to address 0 puts the same data into values 0, 1, 2, 3, 4 and 5.
- R4: In mode 2, a write to address 0 puts the data into values 0, 1, 2 and 3, and values 4 and 5 keep their contents.
- R5: Mode 3 is reserved and behaves exactly like mode 0.
- R6: A `cfg_we` pulse loads `cfg_mode` into the load mode only when `enh_en` is 1. Otherwise the previous mode is kept.
- R7: In every mode, a write to an address from 1 to 5 changes only the value at that address.
- R8: Every target of a broadcast write takes the new data on the same clock edge as value 0.
- R9: `rd_data` returns the stored value at `rd_addr` whatever the mode, and returns 0 for addresses 6 and 7.
- R10: `wr_ready` is always 1, and writes to addresses 6 and 7 change no value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1, the bank accepts every beat |
| wr_addr | input | 3 | Value register index 0 to 5 |
| wr_data | input | 16 | Data to write |
| cfg_we | input | 1 | Load-mode update strobe |
| cfg_mode | input | 2 | New load mode: 0 independent, 1 all, 2 low group, 3 reserved |
| enh_en | input | 1 | Enhanced access enable, gates mode updates |
| rd_addr | input | 3 | Read index |
| rd_data | output | 16 | Value at `rd_addr` |
| duty_vals | output | 96 | Value i at bits [16*i+15:16*i] |

## Verification
A write and a mode update each become visible one edge after the cycle in which they are presented. The read port has no delay. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples shortly after that edge. A mode update affects only writes that come after it, so each table row performs one operation and then reads one location. The same-edge broadcast check compares the whole parallel output right after the writing edge.

// File: rtl/pwmv_pkg.sv
package pwmv_pkg;
  typedef enum logic [1:0] {
    LM_INDEP = 2'b00,
    LM_ALL   = 2'b01,
    LM_LOW   = 2'b10,
    LM_RSV   = 2'b11
  } load_mode_e;
endpackage

// File: rtl/pwmv_mode_reg.sv
module pwmv_mode_reg
  import pwmv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       enh_en,
  output load_mode_e mode_q
);
  // update gated by enhanced access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LM_INDEP;
    end else if (cfg_we && enh_en) begin
      mode_q <= load_mode_e'(cfg_mode);
    end
  end
endmodule

// File: rtl/pwmv_target_decode.sv
module pwmv_target_decode
  import pwmv_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int AW     = 3,
  parameter int LOW_HI = 3
) (
  input  logic          fire,
  input  logic [AW-1:0] addr,
  input  load_mode_e    mode,
  output logic [NUM-1:0] we_mask
);
  logic to_zero;
  assign to_zero = (addr == '0);

  for (genvar i = 0; i < NUM; i++) begin : g_dec
    localparam logic [AW-1:0] IDX = AW'(i);
    logic direct, bcast;
    assign direct = (addr == IDX);
    if (i == 0) begin : g_base
      assign bcast = 1'b0;
    end else if (i <= LOW_HI) begin : g_low
      assign bcast = to_zero && ((mode == LM_ALL) || (mode == LM_LOW));
    end else begin : g_high
      assign bcast = to_zero && (mode == LM_ALL);
    end
    assign we_mask[i] = fire && (direct || bcast);
  end
endmodule

// File: rtl/pwmv_value_bank.sv
module pwmv_value_bank #(
  parameter int NUM = 6,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    we_mask,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NUM*DW-1:0] vals
);
  logic [DW-1:0] regs [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (we_mask[i]) begin
        regs[i] <= wdata;
      end
    end
    assign vals[i*DW +: DW] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/pwmv_bcast_loader.sv
module pwmv_bcast_loader
  import pwmv_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int DW     = 16,
  parameter int LOW_HI = 3,
  localparam int AW    = $clog2(NUM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              enh_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NUM*DW-1:0] duty_vals
);
  load_mode_e     mode_q;
  logic [NUM-1:0] we_mask;

  assign wr_ready = 1'b1;

  pwmv_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .enh_en(enh_en), .mode_q(mode_q)
  );

  pwmv_target_decode #(.NUM(NUM), .AW(AW), .LOW_HI(LOW_HI)) u_dec (
    .fire(wr_valid && wr_ready), .addr(wr_addr), .mode(mode_q), .we_mask(we_mask)
  );

  pwmv_value_bank #(.NUM(NUM), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_mask(we_mask), .wdata(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vals(duty_vals)
  );
endmodule

// File: rtl/pwmv_bcast_loader_chk.sv
module pwmv_bcast_loader_chk
  import pwmv_pkg::*;
#(
  parameter int NUM = 6,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              cfg_we,
  input logic              enh_en,
  input load_mode_e        mode_q,
  input logic [NUM*DW-1:0] duty_vals
);
  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  assert_mode_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && enh_en) |=> $stable(mode_q));

  // R7: a direct write to a nonzero address leaves every other value alone
  for (genvar i = 0; i < NUM; i++) begin : g_keep
    assert_direct_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr != '0 && wr_addr != AW'(i)) |=> $stable(duty_vals[i*DW +: DW]));
  end

  assert_bcast_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == '0 && mode_q == LM_ALL)
      |=> (duty_vals == {NUM{$past(wr_data)}}));

  assert_low_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == '0 && mode_q == LM_LOW)
      |=> ($stable(duty_vals[NUM*DW-1:4*DW]) && duty_vals[4*DW-1:0] == {4{$past(wr_data)}}));

  assert_indep_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == '0 && (mode_q == LM_INDEP || mode_q == LM_RSV))
      |=> $stable(duty_vals[NUM*DW-1:DW]));
endmodule

bind pwmv_bcast_loader pwmv_bcast_loader_chk #(.NUM(NUM), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .cfg_we(cfg_we), .enh_en(enh_en),
  .mode_q(mode_q), .duty_vals(duty_vals)
);

// File: tb/pwmv_bcast_loader_tb.sv
module pwmv_bcast_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        enh_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [95:0] duty_vals;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwmv_bcast_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .enh_en(enh_en), .rd_addr(rd_addr), .rd_data(rd_data), .duty_vals(duty_vals)
  );

  typedef struct packed {
    logic        cw;
    logic        en;
    logic [1:0]  md;
    logic        we;
    logic [2:0]  wa;
    logic [15:0] wd;
    logic [2:0]  ra;
    logic [15:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,2'd1,1'b0,3'd0,16'h0000,3'd0,16'h0000,4'd6},  // R6 mode -> all
    '{1'b0,1'b0,2'd0,1'b1,3'd0,16'h1111,3'd5,16'h1111,4'd3},  // R3
    '{1'b0,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd3,16'h1111,4'd8},  // R8
    '{1'b1,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd4,16'h1111,4'd6},  // R6 blocked
    '{1'b0,1'b0,2'd0,1'b1,3'd0,16'h2222,3'd4,16'h2222,4'd6},  // R6 still all
    '{1'b1,1'b1,2'd2,1'b0,3'd0,16'h0000,3'd1,16'h2222,4'd6},  // R6 mode -> low
    '{1'b0,1'b0,2'd0,1'b1,3'd0,16'h3333,3'd2,16'h3333,4'd4},  // R4
    '{1'b0,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd4,16'h2222,4'd4},  // R4 reg4 kept
    '{1'b0,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd5,16'h2222,4'd4},  // R4 reg5 kept
    '{1'b0,1'b0,2'd0,1'b1,3'd4,16'h4444,3'd4,16'h4444,4'd7},  // R7
    '{1'b0,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd3,16'h3333,4'd7},  // R7 neighbour
    '{1'b1,1'b1,2'd3,1'b0,3'd0,16'h0000,3'd0,16'h3333,4'd9},  // R9 read any mode
    '{1'b0,1'b0,2'd0,1'b1,3'd0,16'h5555,3'd0,16'h5555,4'd5},  // R5
    '{1'b0,1'b0,2'd0,1'b0,3'd0,16'h0000,3'd1,16'h3333,4'd5},  // R5 no fan-out
    '{1'b1,1'b1,2'd0,1'b0,3'd0,16'h0000,3'd1,16'h3333,4'd9},  // R9
    '{1'b0,1'b0,2'd0,1'b1,3'd0,16'h6666,3'd1,16'h3333,4'd2},  // R2
    '{1'b0,1'b0,2'd0,1'b1,3'd6,16'h7777,3'd6,16'h0000,4'd10}, // R10 / R9 addr 6
    '{1'b0,1'b0,2'd0,1'b1,3'd7,16'h7777,3'd0,16'h6666,4'd10}  // R10 addr 7
  };

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 values after reset", duty_vals, 96'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 ready", {95'h0, wr_ready}, 96'h1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      cfg_we = VEC[k].cw; enh_en = VEC[k].en; cfg_mode = VEC[k].md;
      wr_valid = VEC[k].we; wr_addr = VEC[k].wa; wr_data = VEC[k].wd;
      rd_addr = VEC[k].ra;
      step();
      chk($sformatf("R%0d row %0d", VEC[k].req, k), {80'h0, rd_data}, {80'h0, VEC[k].ex});
    end

    // R8: whole parallel output right after a broadcast edge in mode 1
    @(negedge clk);
    wr_valid = 1'b0; cfg_we = 1'b1; enh_en = 1'b1; cfg_mode = 2'd1;
    step();
    @(negedge clk);
    cfg_we = 1'b0; wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 16'hABCD;
    step();
    chk("R8 same edge all six", duty_vals, {6{16'hABCD}});

    // R1: reset mid-run clears values and returns mode to independent
    @(negedge clk);
    wr_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 values cleared", duty_vals, 96'h0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 16'h0F0F;
    step();
    chk("R1 mode back to independent", duty_vals, {80'h0, 16'h0F0F});
    @(negedge clk);
    wr_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule